// File: doc/BRIEF.md
# Outbound Transaction Ordering Queue

This block sits on the outbound path of a bus bridge and holds transactions that wait to be issued. Five transaction classes enter through their own valid/ready ports: posted writes, read requests that need a completion, write requests that need a completion, write completions and read completions. Each transaction carries a tag and an arrival stamp, and the stamp gives its age. Every class has a small in-order queue. One issue port with a valid/ready handshake shows the transaction chosen next.

The choice follows a fixed pass/no-pass matrix. A posted write may overtake anything that is waiting. Nothing may overtake an older posted write. Completions may overtake requests that are held back. Requests that need a completion also use a shared credit: only a limited number of them may be outstanding. A one-cycle completion-return pulse gives a credit back. The pulse does not say which request finished, so issued requests may complete in any order. When several classes are eligible at once, the oldest eligible head wins.

Top module: `oq_outbound_order`

## Requirements
- R1: Posted writes (class code 0) leave the issue port strictly in the order they were accepted.
- R2: A posted write is issued while an older read or write request is held for lack of a credit.
- R3: At most MAX_OUT (default 2) read requests (class code 1) and write requests (class code 2) are outstanding. A request that finds no free credit stays queued. If nothing else is eligible, iss_valid is low.
- R4: Each cpl_ret pulse frees one credit and names no particular request. A pulse while no request is outstanding is ignored: afterwards exactly MAX_OUT requests can be issued, not more and not fewer.
- R5: A write completion (class code 3) or a read completion (class code 4) is issued while an older request is held for lack of a credit.
- R6: No request and no completion is issued while an older posted write is waiting.
- R7: Among the eligible queue heads, the one with the oldest stamp is issued. Stamps are compared modulo 2^STAMP_W, and the live entries are assumed to span less than half that range.
- R8: Each class queue holds DEPTH (default 4) entries. in_ready for a class is low exactly when its queue is full, and a full queue does not affect the other classes.
- R9: Within one class, entries are issued in the order they were accepted.
- R10: After reset every in_ready is high, iss_valid is low and all credits are free. Once iss_valid is high, it stays high until iss_ready takes a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NCLS | Per-class entry valid, indexed by class code |
| in_ready | output | NCLS | Per-class queue has room |
| in_tag | input | NCLS x TAG_W | Per-class entry tag |
| in_stamp | input | NCLS x STAMP_W | Per-class entry arrival stamp |
| iss_valid | output | 1 | A transaction is offered for issue |
| iss_ready | input | 1 | Downstream takes the offered transaction |
| iss_class | output | 3 | Class code of the offered transaction |
| iss_tag | output | TAG_W | Tag of the offered transaction |
| iss_stamp | output | STAMP_W | Stamp of the offered transaction |
| cpl_ret | input | 1 | One-cycle pulse: one outstanding request completed |

## Verification
The assertions assume that stamps rise with arrival and that no entry is accepted with a stamp older than one already waiting. If this does not hold, a new arrival could take the issue port away from an offer that is already shown. They also assume that cpl_ret is pulsed only for requests that were issued, apart from the stray pulses that are deliberately sent while nothing is outstanding. The stimulus gives stamps that rise within each scenario and drains every queue before stamps restart. It sends exactly one return per issued request, plus one extra pulse at zero credits to test the underflow guard.

// File: rtl/oq_pkg.sv
// Shared class encoding for the outbound ordering queue.
// Assumes five classes; the class code doubles as the queue index.
package oq_pkg;
    localparam int NCLS = 5;

    typedef enum logic [2:0] {
        CLS_PW = 3'd0,   // posted write
        CLS_RR = 3'd1,   // read request, needs completion
        CLS_WR = 3'd2,   // write request, needs completion
        CLS_WC = 3'd3,   // write completion
        CLS_RC = 3'd4    // read completion
    } oq_cls_e;
endpackage

// File: rtl/oq_fifo.sv
// Small in-order queue for one transaction class.
// Assumes DEPTH is a power of two; pop is only asserted while head_valid.
module oq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push, take;

    assign in_ready   = (count != CW'(DEPTH));
    assign head_valid = (count != '0);
    assign head_data  = mem[rd_ptr];
    assign push       = in_valid && in_ready;
    assign take       = pop && head_valid;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (take) rd_ptr <= rd_ptr + AW'(1);
            if (push && !take)      count <= count + CW'(1);
            else if (take && !push) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/oq_credit.sv
// Counts outstanding completion-required requests against a fixed cap.
// Assumes take only happens when credit_ok; a give at zero is dropped.
module oq_credit #(
    parameter int MAX_OUT = 2,
    parameter int CW      = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    output logic          credit_ok,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] nxt;

    assign credit_ok = (cnt < CW'(MAX_OUT));

    // Next count: add on issue, subtract on a return that has something to free.
    always_comb begin
        nxt = cnt;
        if (take) nxt = nxt + CW'(1);
        if (give && (cnt != '0)) nxt = nxt - CW'(1);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end
endmodule

// File: rtl/oq_pick.sv
// Applies the pass/no-pass matrix to the queue heads and grants the oldest
// eligible one. Assumes stamps of live entries span under half the stamp range.
module oq_pick
    import oq_pkg::*;
#(
    parameter int NQ      = NCLS,
    parameter int STAMP_W = 8
) (
    input  logic [NQ-1:0]              head_valid,
    input  logic [NQ-1:0][STAMP_W-1:0] head_stamp,
    input  logic                       credit_ok,
    output logic                       grant_valid,
    output logic [2:0]                 grant_idx
);
    logic [NQ-1:0] elig;

    generate
        for (genvar c = 0; c < NQ; c++) begin : g_elig
            logic [STAMP_W-1:0] gap;
            logic               pw_before;
            logic               needs_credit;
            // Signed distance from the posted-write head to this head.
            assign gap          = head_stamp[c] - head_stamp[int'(CLS_PW)];
            assign pw_before    = head_valid[int'(CLS_PW)] && !gap[STAMP_W-1] && (gap != '0);
            assign needs_credit = (c == int'(CLS_RR)) || (c == int'(CLS_WR));
            if (c == int'(CLS_PW)) begin : g_pw
                // Posted writes may pass every other class.
                assign elig[c] = head_valid[c];
            end else begin : g_other
                // Others wait behind older posted writes; requests also need a credit.
                assign elig[c] = head_valid[c] && !pw_before && (!needs_credit || credit_ok);
            end
        end
    endgenerate

    // Oldest-stamp search over eligible heads; lowest code wins a tie.
    always_comb begin
        logic [STAMP_W-1:0] best_st;
        logic [STAMP_W-1:0] diff;
        grant_valid = 1'b0;
        grant_idx   = '0;
        best_st     = '0;
        diff        = '0;
        for (int c = 0; c < NQ; c++) begin
            diff = head_stamp[c] - best_st;
            if (elig[c] && (!grant_valid || diff[STAMP_W-1])) begin
                grant_valid = 1'b1;
                grant_idx   = 3'(c);
                best_st     = head_stamp[c];
            end
        end
    end
endmodule

// File: rtl/oq_outbound_order.sv
// Outbound ordering queue: per-class queues, ordering-matrix selection and a
// cap on completion-required requests. Assumes stamps rise with arrival.
module oq_outbound_order
    import oq_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int STAMP_W = 8,
    parameter int DEPTH   = 4,
    parameter int MAX_OUT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCLS-1:0]              in_valid,
    output logic [NCLS-1:0]              in_ready,
    input  logic [NCLS-1:0][TAG_W-1:0]   in_tag,
    input  logic [NCLS-1:0][STAMP_W-1:0] in_stamp,
    output logic                         iss_valid,
    input  logic                         iss_ready,
    output logic [2:0]                   iss_class,
    output logic [TAG_W-1:0]             iss_tag,
    output logic [STAMP_W-1:0]           iss_stamp,
    input  logic                         cpl_ret
);
    localparam int EW  = TAG_W + STAMP_W;
    localparam int CRW = $clog2(MAX_OUT + 1);

    logic [NCLS-1:0]              head_valid;
    logic [NCLS-1:0]              pop;
    logic [NCLS-1:0][EW-1:0]      head_data;
    logic [NCLS-1:0][TAG_W-1:0]   head_tag;
    logic [NCLS-1:0][STAMP_W-1:0] head_stamp;
    logic                         fire;
    logic                         req_fire;
    logic                         credit_ok;
    logic [CRW-1:0]               cr_cnt;

    assign fire     = iss_valid && iss_ready;
    assign req_fire = fire && ((iss_class == CLS_RR) || (iss_class == CLS_WR));

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_q
            oq_fifo #(.DEPTH(DEPTH), .W(EW)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (in_valid[c]),
                .in_ready  (in_ready[c]),
                .in_data   ({in_tag[c], in_stamp[c]}),
                .pop       (pop[c]),
                .head_valid(head_valid[c]),
                .head_data (head_data[c])
            );
            assign head_tag[c]   = head_data[c][EW-1:STAMP_W];
            assign head_stamp[c] = head_data[c][STAMP_W-1:0];
            assign pop[c]        = fire && (iss_class == 3'(c));
        end
    endgenerate

    oq_credit #(.MAX_OUT(MAX_OUT), .CW(CRW)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (req_fire),
        .give     (cpl_ret),
        .credit_ok(credit_ok),
        .cnt      (cr_cnt)
    );

    oq_pick #(.NQ(NCLS), .STAMP_W(STAMP_W)) u_pick (
        .head_valid (head_valid),
        .head_stamp (head_stamp),
        .credit_ok  (credit_ok),
        .grant_valid(iss_valid),
        .grant_idx  (iss_class)
    );

    // Route the granted head's tag and stamp to the issue port.
    always_comb begin
        iss_tag   = '0;
        iss_stamp = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (iss_class == 3'(c)) begin
                iss_tag   = head_tag[c];
                iss_stamp = head_stamp[c];
            end
        end
    end
endmodule

// File: rtl/oq_order_chk.sv
// Property checker for the outbound ordering queue, bound to the top module.
// Assumes rising stamps and returns only for issued requests (see brief).
module oq_order_chk #(
    parameter int STAMP_W = 8,
    parameter int MAX_OUT = 2,
    parameter int CRW     = $clog2(MAX_OUT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic [2:0]         iss_class,
    input logic [STAMP_W-1:0] iss_stamp,
    input logic               pw_head_valid,
    input logic [STAMP_W-1:0] pw_head_stamp,
    input logic [CRW-1:0]     cr_cnt,
    input logic               cpl_ret,
    input logic               req_fire
);
    logic [STAMP_W-1:0] pw_gap;
    assign pw_gap = iss_stamp - pw_head_stamp;

    // R3: a request is only offered while a credit is free.
    assert_credit_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_class == 3'd1 || iss_class == 3'd2)) |-> (cr_cnt < CRW'(MAX_OUT)));

    // R3: the outstanding count never exceeds the cap.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cr_cnt <= CRW'(MAX_OUT));

    // R4: a return with nothing outstanding leaves the count at zero.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_cnt == '0 && cpl_ret && !req_fire) |=> (cr_cnt == '0));

    // R6: a non-posted-write offer is never younger than a waiting posted write.
    assert_pw_not_passed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class != 3'd0 && pw_head_valid) |-> pw_gap[STAMP_W-1]);

    // R10: an offer stays up until it is taken.
    assert_offer_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> iss_valid);
endmodule

bind oq_outbound_order oq_order_chk #(
    .STAMP_W(STAMP_W),
    .MAX_OUT(MAX_OUT),
    .CRW    (CRW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_ready    (iss_ready),
    .iss_class    (iss_class),
    .iss_stamp    (iss_stamp),
    .pw_head_valid(head_valid[0]),
    .pw_head_stamp(head_stamp[0]),
    .cr_cnt       (cr_cnt),
    .cpl_ret      (cpl_ret),
    .req_fire     (req_fire)
);

// File: tb/oq_outbound_order_tb.sv
// Scoreboard bench: driver tasks queue expected issues, a monitor compares them.
module oq_outbound_order_tb;
    localparam int NC = 5;
    localparam int TW = 8;
    localparam int SW = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NC-1:0]         in_valid = '0;
    logic [NC-1:0]         in_ready;
    logic [NC-1:0][TW-1:0] in_tag = '0;
    logic [NC-1:0][SW-1:0] in_stamp = '0;
    logic                  iss_valid;
    logic                  iss_ready = 1'b0;
    logic [2:0]            iss_class;
    logic [TW-1:0]         iss_tag;
    logic [SW-1:0]         iss_stamp;
    logic                  cpl_ret = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [2:0]    exp_cls [$];
    logic [TW-1:0] exp_tag [$];
    string         exp_req [$];

    always #10 clk = ~clk;   // 50 MHz

    oq_outbound_order u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_stamp(in_stamp), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_class(iss_class), .iss_tag(iss_tag),
        .iss_stamp(iss_stamp), .cpl_ret(cpl_ret)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drive one entry for one cycle; acc reports whether it was accepted.
    task automatic push(input int cls, input logic [TW-1:0] tag, output bit acc);
        @(posedge clk); #1;
        in_valid[cls] = 1'b1;
        in_tag[cls]   = tag;
        in_stamp[cls] = tag;   // stamp equals tag throughout
        @(negedge clk);
        acc = in_ready[cls];
        @(posedge clk); #1;
        in_valid[cls] = 1'b0;
    endtask

    task automatic expect_iss(input int cls, input logic [TW-1:0] tag, input string req);
        exp_cls.push_back(3'(cls));
        exp_tag.push_back(tag);
        exp_req.push_back(req);
    endtask

    task automatic pulse_ret();
        @(posedge clk); #1;
        cpl_ret = 1'b1;
        @(posedge clk); #1;
        cpl_ret = 1'b0;
    endtask

    // Monitor: a handshake seen at negedge completes at the next posedge.
    always @(negedge clk) begin
        if (rst_n && iss_valid && iss_ready) begin
            if (exp_cls.size() == 0) begin
                check(1'b0, "R3 unexpected issue", int'(iss_tag), -1);
            end else begin
                logic [2:0]    ec;
                logic [TW-1:0] et;
                string         er;
                ec = exp_cls.pop_front();
                et = exp_tag.pop_front();
                er = exp_req.pop_front();
                check(iss_class == ec, {er, " class"}, int'(iss_class), int'(ec));
                check(iss_tag == et, {er, " tag"}, int'(iss_tag), int'(et));
            end
        end
    end

    task automatic check_drained(input string req);
        check(exp_cls.size() == 0, req, exp_cls.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit acc;
        cyc(3);
        @(negedge clk);
        check(in_ready == 5'b11111, "R10 reset ready", int'(in_ready), 31);
        check(iss_valid == 1'b0, "R10 reset valid", int'(iss_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc(1);
        @(negedge clk);
        check(iss_valid == 1'b0, "R10 idle after reset", int'(iss_valid), 0);

        // R1/R9/R6: posted writes in order, the completion waits behind them.
        push(0, 8'd1, acc); push(0, 8'd2, acc); push(0, 8'd3, acc); push(4, 8'd4, acc);
        @(negedge clk);
        check(iss_valid && iss_class == 3'd0, "R6 posted write offered first", int'(iss_class), 0);
        expect_iss(0, 8'd1, "R1"); expect_iss(0, 8'd2, "R1");
        expect_iss(0, 8'd3, "R9"); expect_iss(4, 8'd4, "R6");
        cyc(1); iss_ready = 1'b1;
        cyc(6);
        check_drained("R1 drained");

        // R7: oldest eligible head wins across classes.
        iss_ready = 1'b0;
        push(3, 8'd60, acc); push(4, 8'd58, acc); push(2, 8'd59, acc); push(0, 8'd61, acc);
        expect_iss(4, 8'd58, "R7"); expect_iss(2, 8'd59, "R7");
        expect_iss(3, 8'd60, "R7"); expect_iss(0, 8'd61, "R7");
        cyc(1); iss_ready = 1'b1;
        cyc(6);
        check_drained("R7 drained");
        pulse_ret();   // return the write request

        // R3/R2/R5: third request held; posted write and completion pass it.
        expect_iss(1, 8'd30, "R3"); expect_iss(1, 8'd31, "R3");
        expect_iss(0, 8'd33, "R2"); expect_iss(3, 8'd34, "R5");
        push(1, 8'd30, acc); push(1, 8'd31, acc); push(1, 8'd32, acc);
        push(0, 8'd33, acc); push(3, 8'd34, acc);
        cyc(3);
        @(negedge clk);
        check(iss_valid == 1'b0, "R3 held without credit", int'(iss_valid), 0);
        check_drained("R5 drained");
        expect_iss(1, 8'd32, "R4");
        pulse_ret();
        cyc(3);
        check_drained("R4 credit freed");

        // R4: return everything, then one stray pulse at zero.
        pulse_ret(); pulse_ret(); pulse_ret();
        iss_ready = 1'b0;
        push(2, 8'd40, acc); push(2, 8'd41, acc); push(2, 8'd42, acc);
        expect_iss(2, 8'd40, "R4"); expect_iss(2, 8'd41, "R4");
        cyc(1); iss_ready = 1'b1;
        cyc(4);
        @(negedge clk);
        check_drained("R4 exactly cap issued");
        check(iss_valid == 1'b0, "R4 no extra credit", int'(iss_valid), 0);
        expect_iss(2, 8'd42, "R4");
        pulse_ret();
        cyc(3);
        check_drained("R4 last request");
        pulse_ret(); pulse_ret();

        // R8: queue depth and in_ready.
        iss_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push(0, 8'(70 + i), acc);
            check(acc == 1'b1, "R8 accept below depth", int'(acc), 1);
        end
        push(0, 8'd74, acc);
        check(acc == 1'b0, "R8 full refuses", int'(acc), 0);
        @(negedge clk);
        check(in_ready == 5'b11110, "R8 only full class not ready", int'(in_ready), 30);
        for (int i = 0; i < 4; i++) expect_iss(0, 8'(70 + i), "R8");
        cyc(1); iss_ready = 1'b1;
        cyc(6);
        check_drained("R8 drained");
        @(negedge clk);
        check(in_ready == 5'b11111, "R8 ready again", int'(in_ready), 31);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule